// File: doc/BRIEF.md
# Fractional Scale-Step Baud Generator

This block produces a one-cycle enable pulse for a serial shifter. The pulse rate is set by two numbers held in one configuration word. The first is a coarse integer prescaler, `scale`, which divides the input clock by `scale + 1`. The second is a 16-bit fractional `step`. Each time the prescaler completes a period, `step` is added into a 17-bit phase accumulator. Every carry out of that accumulator is a tick. On average the tick rate is clk / (scale + 1) × step / 2^17.

Software writes the packed configuration word and pulses the load strobe. The load also restarts both counters from zero, so the first tick after a load always falls in the same place. When the enable input is low, all state freezes and the tick stays low.

Top module: `frac_baud_gen`

## Requirements
- R1: The configuration word holds `step` in bits [15:0] and `scale` in bits [23:16]. Bits [31:24] of the written word are ignored. `cfg_readback` returns `{8'h00, scale, step}` from the cycle after the load edge. After reset it reads zero.
- R2: After a load, take the next N clock cycles with `enable` high. The number of ticks in them is exactly floor(floor(N / (scale+1)) × step / 2^17).
- R3: When `step` is zero, `tick` never rises.
- R4: Each tick lasts exactly one clock cycle. Because `step` is below 2^16, two ticks never fall in adjacent cycles.
- R5: While `enable` is low, `tick` is low and the prescaler and accumulator hold their values. A run broken by disabled cycles gives the same tick count as an unbroken run with the same number of enabled cycles.
- R6: A load clears the prescaler and the accumulator, and `tick` is low in the cycle in which the load is asserted. Counting after a reload in the middle of a run starts again from phase zero.
- R7: The extreme settings follow the same formula. With scale = 0 and step = 0xFFFF the rate is just under half the clock. With scale = 0xFF and step = 1 the rate is the slowest possible, and a window of a few thousand cycles holds no ticks.
- R8: After synchronous reset, `tick` is low and the configuration is zero, so no ticks are produced until a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Strobe that captures `cfg_word` and clears the phase |
| cfg_word | input | 32 | Packed configuration: scale in [23:16], step in [15:0] |
| enable | input | 1 | Runs the counters when high; freezes them when low |
| tick | output | 1 | One-cycle rate pulse |
| cfg_readback | output | 32 | Held configuration, with bits [31:24] zero |

## Verification
`tick` is driven without a register: it is high in the same cycle as the prescaler wrap whose addition carries out of the accumulator. The bench therefore samples `tick` at the falling edge that follows each enabled rising edge, and counts exactly N such samples per window. `cfg_readback` is registered and is first read at the falling edge after the load edge. The rising edge that takes the load also sets the prescaler to count zero, so the first counted sample is cycle 0 of the new phase. Disabled cycles are sampled as well, and they must show `tick` low.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

    localparam int SCALE_W   = 8;
    localparam int STEP_W    = 16;
    localparam int CFG_W     = 32;
    localparam int SCALE_LSB = 16;
    localparam int PHASE_W   = STEP_W + 1;

    typedef struct packed {
        logic [SCALE_W-1:0] scale;
        logic [STEP_W-1:0]  step;
    } rate_cfg_t;

    typedef struct packed {
        logic wrap;
        logic carry;
    } phase_evt_t;

    function automatic rate_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        rate_cfg_t r;
        r.scale = w[SCALE_LSB +: SCALE_W];
        r.step  = w[STEP_W-1:0];
        return r;
    endfunction

    function automatic logic [CFG_W-1:0] pack_cfg(input rate_cfg_t c);
        logic [CFG_W-1:0] w;
        w = '0;
        w[SCALE_LSB +: SCALE_W] = c.scale;
        w[STEP_W-1:0]           = c.step;
        return w;
    endfunction

endpackage

// File: rtl/frac_baud_cfg_reg.sv
module frac_baud_cfg_reg
    import frac_baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CFG_W-1:0] word_i,
    output rate_cfg_t        cfg_o,
    output logic [CFG_W-1:0] readback_o
);

    rate_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (load_i) begin
            cfg_q <= unpack_cfg(word_i);
        end
    end

    assign cfg_o      = cfg_q;
    assign readback_o = pack_cfg(cfg_q);

    // R1: a load is visible on the readback one cycle later, with the top byte dropped
    p_readback_load_r1: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (readback_o[SCALE_LSB+SCALE_W-1:0] == $past(word_i[SCALE_LSB+SCALE_W-1:0])));

    // R1: without a load the held configuration does not move
    p_cfg_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(cfg_q));

endmodule

// File: rtl/frac_baud_prescaler.sv
module frac_baud_prescaler #(
    parameter int CNT_W = frac_baud_pkg::SCALE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             wrap_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             at_limit;

    assign at_limit = (cnt_q == limit_i);
    assign wrap_o   = run_i && at_limit;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
        end
    end

    // R2: the count never passes the programmed limit
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= limit_i);

    // R6: a clear restarts the prescaler at zero
    p_cnt_clear_r6: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (cnt_q == '0));

    // R5: an idle cycle leaves the count unchanged
    p_cnt_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !clear_i) |=> $stable(cnt_q));

endmodule

// File: rtl/frac_baud_phase_acc.sv
module frac_baud_phase_acc #(
    parameter int STEP_W = frac_baud_pkg::STEP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              add_i,
    input  logic [STEP_W-1:0] step_i,
    output logic              carry_o
);

    localparam int PH_W  = STEP_W + 1;
    localparam int SUM_W = PH_W + 1;

    logic [PH_W-1:0]  acc_q;
    logic [SUM_W-1:0] sum;

    assign sum     = {1'b0, acc_q} + {{(SUM_W-STEP_W){1'b0}}, step_i};
    assign carry_o = add_i && sum[PH_W];

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            acc_q <= '0;
        end else if (add_i) begin
            acc_q <= sum[PH_W-1:0];
        end
    end

    // R6: a clear restarts the phase at zero
    p_acc_clear_r6: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (acc_q == '0));

    // R5: no addition, no phase change
    p_acc_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!add_i && !clear_i) |=> $stable(acc_q));

    // R4: a carry leaves the phase below one step, so the next add cannot carry
    p_acc_after_carry_r4: assert property (@(posedge clk) disable iff (rst)
        (carry_o && !clear_i) |=> (acc_q < {1'b0, $past(step_i)}));

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import frac_baud_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_load,
    input  logic [31:0] cfg_word,
    input  logic        enable,
    output logic        tick,
    output logic [31:0] cfg_readback
);

    rate_cfg_t  cfg;
    phase_evt_t evt;
    logic       run;

    assign run = enable && !cfg_load;

    frac_baud_cfg_reg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .load_i     (cfg_load),
        .word_i     (cfg_word),
        .cfg_o      (cfg),
        .readback_o (cfg_readback)
    );

    frac_baud_prescaler #(.CNT_W(SCALE_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .clear_i (cfg_load),
        .run_i   (run),
        .limit_i (cfg.scale),
        .wrap_o  (evt.wrap)
    );

    frac_baud_phase_acc #(.STEP_W(STEP_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clear_i (cfg_load),
        .add_i   (evt.wrap),
        .step_i  (cfg.step),
        .carry_o (evt.carry)
    );

    assign tick = evt.carry;

    // R4: a tick is a single-cycle pulse
    p_single_tick_r4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R5: disabled means quiet
    p_idle_low_r5: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !tick);

    // R3: a zero step never ticks
    p_zero_step_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_readback[STEP_W-1:0] == '0) |-> !tick);

    // R6: the load cycle itself is quiet
    p_load_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_load |-> !tick);

endmodule

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;

    typedef struct packed {
        logic [7:0]  sc;
        logic [15:0] st;
        logic [19:0] n;
    } vec_t;

    // scale, step, window length in enabled cycles
    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'd0,   16'hFFFF, 20'd1000},   // R7 fastest
        '{8'd255, 16'hFFFF, 20'd4096},   // R7 largest scale
        '{8'd255, 16'h0001, 20'd3000},   // R7 slowest
        '{8'd0,   16'h0000, 20'd2000},   // R3 zero step
        '{8'd9,   16'h4000, 20'd5000},
        '{8'd3,   16'h8000, 20'd4000},
        '{8'd100, 16'h1234, 20'd20000},
        '{8'd1,   16'h0001, 20'd3000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_load = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        enable = 1'b0;
    logic        tick;
    logic [31:0] cfg_readback;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    frac_baud_gen uut (
        .clk          (clk),
        .rst          (rst),
        .cfg_load     (cfg_load),
        .cfg_word     (cfg_word),
        .enable       (enable),
        .tick         (tick),
        .cfg_readback (cfg_readback)
    );

    function automatic longint exp_ticks(input int sc, input int st, input int n);
        longint w;
        w = longint'(n / (sc + 1));
        return (w * longint'(st)) >>> 17;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the load edge
    task automatic do_load(input logic [31:0] w);
        cfg_word = w;
        cfg_load = 1'b1;
        #1;
        check("R6 tick low in load cycle", longint'(tick), 0);
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // counts ticks over n enabled cycles; gaps inserts disabled cycles
    task automatic run_window(input int n, input bit gaps, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 3 == 1)) begin
                enable = 1'b0;
                #1;
                if (tick) begin
                    fails++;
                    $display("FAIL R5 tick during disable: actual 1 expected 0");
                end
                @(negedge clk);
            end
            enable = 1'b1;
            #1;
            if (tick) cnt++;
            @(negedge clk);
        end
        enable = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 tick after reset", longint'(tick), 0);
        check("R8 readback after reset", longint'(cfg_readback), 0);
        rst = 1'b0;
        @(negedge clk);
        run_window(300, 1'b0, c);
        check("R8 no ticks before any load", c, 0);

        // R2 table of rates
        for (int v = 0; v < NV; v++) begin
            do_load({8'h00, VECS[v].sc, VECS[v].st});
            run_window(int'(VECS[v].n), 1'b0, c);
            check("R2 tick count", c,
                  exp_ticks(int'(VECS[v].sc), int'(VECS[v].st), int'(VECS[v].n)));
        end

        // R7 fastest rate is below half the clock
        do_load({8'h00, 8'h00, 16'hFFFF});
        run_window(2000, 1'b0, c);
        check("R7 fastest under half", longint'(c < 1000), 1);

        // R1 field positions, ignored top byte
        do_load(32'hAB01_8000);
        check("R1 readback", longint'(cfg_readback), 64'h0001_8000);
        run_window(4000, 1'b0, c);
        check("R1 scale/step decode", c, exp_ticks(1, 32'h8000, 4000));

        // R5 gaps do not change the count
        do_load({8'h00, 8'd3, 16'h8000});
        run_window(3000, 1'b1, c);
        check("R5 count with gaps", c, exp_ticks(3, 32'h8000, 3000));
        do_load({8'h00, 8'd0, 16'hFFFF});
        run_window(1500, 1'b1, c);
        check("R5 fast count with gaps", c, exp_ticks(0, 32'hFFFF, 1500));

        // R6 reload mid-run restarts the phase
        do_load({8'h00, 8'd2, 16'h7777});
        run_window(777, 1'b0, c);
        do_load({8'h00, 8'd2, 16'h7777});
        run_window(3001, 1'b0, c);
        check("R6 count after reload", c, exp_ticks(2, 32'h7777, 3001));

        // R3 zero step with enable held for a long stretch
        do_load({8'h00, 8'd0, 16'h0000});
        run_window(5000, 1'b0, c);
        check("R3 zero step silent", c, 0);

        // R8 reset mid-run clears configuration
        do_load({8'h00, 8'd0, 16'hFFFF});
        rst = 1'b1;
        @(negedge clk);
        check("R8 readback after second reset", longint'(cfg_readback), 0);
        rst = 1'b0;
        run_window(500, 1'b0, c);
        check("R8 silent after second reset", c, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule